// File: doc/BRIEF.md
# Direct Power Control Vector Selector

This block chooses the switching state of a three-phase, two-level inverter directly. It does not use a modulator. Two signed power errors drive two hysteresis comparators. The error with respect to active power uses band `hp`, and the error with respect to reactive power uses band `hq`. Each comparator yields one bit that says whether its power must rise or fall.

The grid-voltage vector, given by its alpha and beta components, is placed in one of twelve 30-degree sectors. Only sign tests and constant-coefficient magnitude comparisons do this; no angle is ever computed. The two bits and the sector then index a fixed table. The table returns the on/off state of the three inverter legs.

All state advances only on a sample strobe. The chosen state, the two error bits and the sector number are held in registers until the next strobe. A surrounding controller supplies the errors once per control period and drives the inverter gates from the registered state.

Top module: `dpc_vector_sel`

## Requirements
- R1: On a strobe, the active-power bit `dp_bit` becomes 1 when `p_err > hp` and becomes 0 when `p_err < -hp`. Signed comparison is used, and the thresholds are strict.
- R2: On a strobe, the reactive-power bit `dq_bit` becomes 1 when `q_err > hq` and becomes 0 when `q_err < -hq`. The comparison is signed and strict.
- R3: On a strobe, an error whose value lies in the closed interval from minus its band to plus its band leaves its bit unchanged. This includes an error exactly equal to the band.
- R4: While reset is held, `sw_state` is 3'b000, both error bits are 0, and `sector` reads 1.
- R5: `sector` is a binary number from 1 to 12. Sector k covers angles from (k-1)·30° − 15° to (k-1)·30° + 15°. The angle is measured counter-clockwise from the positive alpha axis, toward positive beta. A zero voltage vector reports sector 1.
- R6: `sw_state` holds the bits {Sa,Sb,Sc}, with Sa as the MSB. The codes are: V0=000, V1=100, V2=110, V3=010, V4=011, V5=001, V6=101, V7=111. With dp=1 and dq=0, sectors 1 to 12 select V6,V7,V1,V0,V2,V7,V3,V0,V4,V7,V5,V0.
- R7: With dp=1 and dq=1, sectors 1 to 12 select V7,V7,V0,V0,V7,V7,V0,V0,V7,V7,V0,V0. The state is therefore always 000 or 111.
- R8: With dp=0 and dq=0, sectors 1 to 12 select V6,V1,V1,V2,V2,V3,V3,V4,V4,V5,V5,V6. With dp=0 and dq=1, they select V1,V2,V2,V3,V3,V4,V4,V5,V5,V6,V6,V1.
- R9: All outputs change only at a clock edge where `sample_en` is 1. They show the result one cycle later. `sw_state` is looked up from the bits updated by that same sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sample strobe; one cycle per control period |
| p_err | input | W | Signed active-power error |
| q_err | input | W | Signed reactive-power error |
| hp | input | W | Active-power band half-width, non-negative |
| hq | input | W | Reactive-power band half-width, non-negative |
| v_alpha | input | W | Signed alpha component of grid voltage |
| v_beta | input | W | Signed beta component of grid voltage |
| sw_state | output | 3 | Registered leg states {Sa,Sb,Sc} |
| dp_bit | output | 1 | Registered active-power hysteresis bit |
| dq_bit | output | 1 | Registered reactive-power hysteresis bit |
| sector | output | 4 | Registered sector number, 1 to 12 |

## Verification
The hysteresis bits are the only state carried from sample to sample. If a bit is lost or flipped, it is visible on `dp_bit`/`dq_bit` and on `sw_state` in the cycle right after the next strobe whose error lies inside its band. That is the point at which a correct design must repeat its previous value.

A wrong sector boundary or a wrong quadrant fold is visible immediately in the `sector` output after a strobe with a vector a few degrees away from the affected boundary. A wrong table entry shows on `sw_state` for only one of the 48 bit-and-sector combinations, so every combination is driven.

// File: rtl/dpc_vsel_pkg.sv
package dpc_vsel_pkg;

  typedef logic [2:0] sw_code_t;

  localparam int NSEC  = 12;
  localparam int SEC_W = 4;

  // vector number (0..7) to leg state {Sa,Sb,Sc}
  function automatic sw_code_t vec_code(input int unsigned n);
    sw_code_t c;
    case (n)
      1: c = 3'b100;
      2: c = 3'b110;
      3: c = 3'b010;
      4: c = 3'b011;
      5: c = 3'b001;
      6: c = 3'b101;
      7: c = 3'b111;
      default: c = 3'b000;
    endcase
    return c;
  endfunction

  // vector numbers per sector index 0..11, one row per (dp,dq)
  localparam int unsigned ROW_P1Q0 [NSEC] = '{6, 7, 1, 0, 2, 7, 3, 0, 4, 7, 5, 0};
  localparam int unsigned ROW_P1Q1 [NSEC] = '{7, 7, 0, 0, 7, 7, 0, 0, 7, 7, 0, 0};
  localparam int unsigned ROW_P0Q0 [NSEC] = '{6, 1, 1, 2, 2, 3, 3, 4, 4, 5, 5, 6};
  localparam int unsigned ROW_P0Q1 [NSEC] = '{1, 2, 2, 3, 3, 4, 4, 5, 5, 6, 6, 1};

  function automatic sw_code_t pick_vector(input logic dp, input logic dq,
                                           input logic [SEC_W-1:0] idx);
    int unsigned n;
    int unsigned k;
    k = int'(idx);
    if (k >= NSEC) k = 0;
    case ({dp, dq})
      2'b10:   n = ROW_P1Q0[k];
      2'b11:   n = ROW_P1Q1[k];
      2'b00:   n = ROW_P0Q0[k];
      default: n = ROW_P0Q1[k];
    endcase
    return vec_code(n);
  endfunction

endpackage

// File: rtl/dpc_hyst_cmp.sv
module dpc_hyst_cmp #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] err,
  input  logic signed [W-1:0] band,
  input  logic                cur,
  output logic                nxt
);
  // one extra bit so that -band never overflows
  logic signed [W:0] err_x;
  logic signed [W:0] hi_x;
  logic signed [W:0] lo_x;

  always_comb begin
    err_x = {err[W-1], err};
    hi_x  = {band[W-1], band};
    lo_x  = -hi_x;
    if (err_x > hi_x)
      nxt = 1'b1;
    else if (err_x < lo_x)
      nxt = 1'b0;
    else
      nxt = cur;
  end
endmodule

// File: rtl/dpc_sector_find.sv
module dpc_sector_find #(
  parameter int W    = 16,
  parameter int FRAC = 12
) (
  input  logic signed [W-1:0]               v_a,
  input  logic signed [W-1:0]               v_b,
  output logic [dpc_vsel_pkg::SEC_W-1:0]    idx
);
  localparam int PW = W + FRAC + 2;
  localparam int unsigned K_LO = $rtoi(0.2679491924 * real'(1 << FRAC) + 0.5);
  localparam int unsigned K_HI = $rtoi(3.7320508076 * real'(1 << FRAC) + 0.5);
  localparam logic [PW-1:0] K_LO_W = PW'(K_LO);
  localparam logic [PW-1:0] K_HI_W = PW'(K_HI);

  logic [W-1:0]  ax, ay;
  logic [PW-1:0] ay_s, lim_lo, lim_hi;
  logic [1:0]    zone;
  logic          neg_a, neg_b;

  always_comb begin
    neg_a  = v_a[W-1];
    neg_b  = v_b[W-1];
    ax     = neg_a ? W'(0 - v_a) : W'(v_a);
    ay     = neg_b ? W'(0 - v_b) : W'(v_b);
    ay_s   = PW'(ay) << FRAC;
    lim_lo = PW'(ax) * K_LO_W;
    lim_hi = PW'(ax) * K_HI_W;
    // folded angle: 0..15, 15..45, 45..75, 75..90 degrees
    if (ay_s <= lim_lo)
      zone = 2'd0;
    else if (ay <= ax)
      zone = 2'd1;
    else if (ay_s <= lim_hi)
      zone = 2'd2;
    else
      zone = 2'd3;
    case ({neg_a, neg_b})
      2'b00: idx = {2'b00, zone};
      2'b10: idx = 4'd6 - {2'b00, zone};
      2'b11: idx = 4'd6 + {2'b00, zone};
      default: idx = (zone == 2'd0) ? 4'd0 : 4'd12 - {2'b00, zone};
    endcase
  end
endmodule

// File: rtl/dpc_vec_lut.sv
module dpc_vec_lut (
  input  logic                            dp,
  input  logic                            dq,
  input  logic [dpc_vsel_pkg::SEC_W-1:0]  idx,
  output dpc_vsel_pkg::sw_code_t          code
);
  always_comb code = dpc_vsel_pkg::pick_vector(dp, dq, idx);
endmodule

// File: rtl/dpc_vector_sel.sv
module dpc_vector_sel #(
  parameter int W    = 16,
  parameter int FRAC = 12
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sample_en,
  input  logic signed [W-1:0]               p_err,
  input  logic signed [W-1:0]               q_err,
  input  logic signed [W-1:0]               hp,
  input  logic signed [W-1:0]               hq,
  input  logic signed [W-1:0]               v_alpha,
  input  logic signed [W-1:0]               v_beta,
  output logic [2:0]                        sw_state,
  output logic                              dp_bit,
  output logic                              dq_bit,
  output logic [dpc_vsel_pkg::SEC_W-1:0]    sector
);
  localparam int SW    = dpc_vsel_pkg::SEC_W;
  localparam int NCOMP = 2;

  logic signed [W-1:0] err_a  [NCOMP];
  logic signed [W-1:0] band_a [NCOMP];
  logic [NCOMP-1:0]    bit_q, bit_d;
  logic [SW-1:0]       sec_idx, sec_d, sec_q;
  logic [2:0]          code_d, code_q;

  assign err_a[0]  = p_err;
  assign err_a[1]  = q_err;
  assign band_a[0] = hp;
  assign band_a[1] = hq;

  for (genvar c = 0; c < NCOMP; c++) begin : g_hyst
    dpc_hyst_cmp #(.W(W)) u_cmp (
      .err  (err_a[c]),
      .band (band_a[c]),
      .cur  (bit_q[c]),
      .nxt  (bit_d[c])
    );
  end

  dpc_sector_find #(.W(W), .FRAC(FRAC)) u_sec (
    .v_a (v_alpha),
    .v_b (v_beta),
    .idx (sec_idx)
  );

  dpc_vec_lut u_lut (
    .dp   (bit_d[0]),
    .dq   (bit_d[1]),
    .idx  (sec_idx),
    .code (code_d)
  );

  always_comb sec_d = sec_idx + SW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      sec_q  <= SW'(1);
      code_q <= 3'b000;
    end else if (sample_en) begin
      bit_q  <= bit_d;
      sec_q  <= sec_d;
      code_q <= code_d;
    end
  end

  assign sw_state = code_q;
  assign dp_bit   = bit_q[0];
  assign dq_bit   = bit_q[1];
  assign sector   = sec_q;
endmodule

// File: rtl/dpc_vector_sel_chk.sv
module dpc_vector_sel_chk #(
  parameter int W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sample_en,
  input logic signed [W-1:0] p_err,
  input logic signed [W-1:0] q_err,
  input logic signed [W-1:0] hp,
  input logic signed [W-1:0] hq,
  input logic [2:0]          sw_state,
  input logic                dp_bit,
  input logic                dq_bit,
  input logic [3:0]          sector
);
  logic signed [W:0] pe, qe, hpx, hqx;
  assign pe  = {p_err[W-1], p_err};
  assign qe  = {q_err[W-1], q_err};
  assign hpx = {hp[W-1], hp};
  assign hqx = {hq[W-1], hq};

  // R1
  dp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && pe > hpx) |=> dp_bit);
  // R1
  dp_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && pe < -hpx) |=> !dp_bit);
  // R2
  dq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && qe > hqx) |=> dq_bit);
  // R2
  dq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && qe < -hqx) |=> !dq_bit);
  // R3
  dp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && pe <= hpx && pe >= -hpx) |=> $stable(dp_bit));
  // R3
  dq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && qe <= hqx && qe >= -hqx) |=> $stable(dq_bit));
  // R5
  sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sector >= 4'd1 && sector <= 4'd12));
  // R7
  both_up_zero_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_bit && dq_bit) |-> (sw_state == 3'b000 || sw_state == 3'b111));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> ($stable(sw_state) && $stable(sector) &&
                    $stable(dp_bit) && $stable(dq_bit)));
endmodule

bind dpc_vector_sel dpc_vector_sel_chk #(.W(W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .sample_en (sample_en),
  .p_err     (p_err),
  .q_err     (q_err),
  .hp        (hp),
  .hq        (hq),
  .sw_state  (sw_state),
  .dp_bit    (dp_bit),
  .dq_bit    (dq_bit),
  .sector    (sector)
);

// File: tb/dpc_vector_sel_tb_top.sv
`timescale 1ns/1ps
module dpc_vector_sel_tb_top;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic sample_en;
  logic signed [W-1:0] p_err, q_err, hp, hq, v_alpha, v_beta;
  logic [2:0] sw_state;
  logic dp_bit, dq_bit;
  logic [3:0] sector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dpc_vector_sel #(.W(W), .FRAC(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en),
    .p_err(p_err), .q_err(q_err), .hp(hp), .hq(hq),
    .v_alpha(v_alpha), .v_beta(v_beta),
    .sw_state(sw_state), .dp_bit(dp_bit), .dq_bit(dq_bit), .sector(sector)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected leg state from the requirement tables, codes written directly
  function automatic int exp_code(input bit dp, input bit dq, input int s);
    int r11 [12] = '{7, 7, 0, 0, 7, 7, 0, 0, 7, 7, 0, 0};
    int r10 [12] = '{5, 7, 4, 0, 6, 7, 2, 0, 3, 7, 1, 0};
    int r00 [12] = '{5, 4, 4, 6, 6, 2, 2, 3, 3, 1, 1, 5};
    int r01 [12] = '{4, 6, 6, 2, 2, 3, 3, 1, 1, 5, 5, 4};
    if (dp && dq)  return r11[s-1];
    if (dp)        return r10[s-1];
    if (dq)        return r01[s-1];
    return r00[s-1];
  endfunction

  function automatic int exp_sector(input int va, input int vb);
    real deg;
    int  k;
    if (va == 0 && vb == 0) return 1;
    deg = $atan2(real'(vb), real'(va)) * 180.0 / 3.14159265358979;
    if (deg < 0.0) deg = deg + 360.0;
    k = $rtoi((deg + 15.0) / 30.0) % 12;
    return k + 1;
  endfunction

  task automatic do_sample(input int pe, input int qe, input int va, input int vb);
    @(negedge clk);
    p_err = W'(pe); q_err = W'(qe); v_alpha = W'(va); v_beta = W'(vb);
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
  endtask

  task automatic t_reset;
    check("R4 sw_state", int'(sw_state), 0);
    check("R4 dp_bit", int'(dp_bit), 0);
    check("R4 dq_bit", int'(dq_bit), 0);
    check("R4 sector", int'(sector), 1);
  endtask

  task automatic t_hysteresis;
    hp = 100; hq = 200;
    do_sample(150, 0, 1000, 0);
    check("R1 dp set above +hp", int'(dp_bit), 1);
    do_sample(100, 0, 1000, 0);
    check("R3 dp hold at +hp", int'(dp_bit), 1);
    do_sample(-100, 0, 1000, 0);
    check("R3 dp hold at -hp", int'(dp_bit), 1);
    do_sample(-101, 0, 1000, 0);
    check("R1 dp clear below -hp", int'(dp_bit), 0);
    do_sample(60, 0, 1000, 0);
    check("R3 dp hold low inside band", int'(dp_bit), 0);
    do_sample(0, 201, 1000, 0);
    check("R2 dq set above +hq", int'(dq_bit), 1);
    do_sample(0, -150, 1000, 0);
    check("R3 dq hold inside band", int'(dq_bit), 1);
    do_sample(0, -201, 1000, 0);
    check("R2 dq clear below -hq", int'(dq_bit), 0);
    do_sample(0, 200, 1000, 0);
    check("R3 dq hold at +hq", int'(dq_bit), 0);
    do_sample(-32768, 32767, 1000, 0);
    check("R1 dp clear at full-scale negative", int'(dp_bit), 0);
    check("R2 dq set at full-scale positive", int'(dq_bit), 1);
  endtask

  task automatic t_sectors;
    hp = 100; hq = 100;
    for (int c = 0; c < 12; c++) begin
      for (int side = -1; side <= 1; side += 2) begin
        real a;
        int va, vb;
        a  = (real'(c * 30 + side * 11)) * 3.14159265358979 / 180.0;
        va = $rtoi(20000.0 * $cos(a));
        vb = $rtoi(20000.0 * $sin(a));
        do_sample(0, 0, va, vb);
        check($sformatf("R5 sector at %0d deg", c * 30 + side * 11),
              int'(sector), exp_sector(va, vb));
      end
    end
    do_sample(0, 0, 0, 0);
    check("R5 zero vector", int'(sector), 1);
    do_sample(0, 0, -32768, 0);
    check("R5 full-scale negative alpha", int'(sector), 7);
    do_sample(0, 0, 0, -32768);
    check("R5 full-scale negative beta", int'(sector), 10);
    do_sample(0, 0, 3, 32000);
    check("R5 near +beta axis", int'(sector), 4);
  endtask

  task automatic t_table;
    hp = 100; hq = 100;
    for (int combo = 0; combo < 4; combo++) begin
      bit dp, dq;
      dp = combo[1];
      dq = combo[0];
      for (int s = 1; s <= 12; s++) begin
        real a;
        int va, vb;
        a  = (real'((s - 1) * 30 + 4)) * 3.14159265358979 / 180.0;
        va = $rtoi(15000.0 * $cos(a));
        vb = $rtoi(15000.0 * $sin(a));
        do_sample(dp ? 500 : -500, dq ? 500 : -500, va, vb);
        if (dp && dq)
          check($sformatf("R7 table dp1 dq1 sector %0d", s), int'(sw_state), exp_code(dp, dq, s));
        else if (dp)
          check($sformatf("R6 table dp1 dq0 sector %0d", s), int'(sw_state), exp_code(dp, dq, s));
        else
          check($sformatf("R8 table dp0 dq%0d sector %0d", dq, s), int'(sw_state), exp_code(dp, dq, s));
      end
    end
    // bit held inside band still drives the table: dp=1 held, dq=0 held
    do_sample(500, -500, 15000, 0);
    do_sample(20, -20, 0, 15000);
    check("R9 lookup uses held bits", int'(sw_state), exp_code(1, 0, 4));
  endtask

  task automatic t_strobe;
    int s0, c0, d0, q0;
    hp = 100; hq = 100;
    do_sample(500, -500, 15000, 2000);
    s0 = int'(sector); c0 = int'(sw_state); d0 = int'(dp_bit); q0 = int'(dq_bit);
    @(negedge clk);
    p_err = -500; q_err = 500; v_alpha = -15000; v_beta = -9000;
    repeat (4) @(negedge clk);
    check("R9 sector held without strobe", int'(sector), s0);
    check("R9 sw_state held without strobe", int'(sw_state), c0);
    check("R9 dp held without strobe", int'(dp_bit), d0);
    check("R9 dq held without strobe", int'(dq_bit), q0);
    sample_en = 1'b1;
    @(negedge clk);
    sample_en = 1'b0;
    check("R9 update after strobe sector", int'(sector), exp_sector(-15000, -9000));
    check("R9 update after strobe state", int'(sw_state),
          exp_code(0, 1, exp_sector(-15000, -9000)));
  endtask

  initial begin
    rst_n = 1'b0; sample_en = 1'b0;
    p_err = '0; q_err = '0; hp = '0; hq = '0; v_alpha = '0; v_beta = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hysteresis();
    t_sectors();
    t_table();
    t_strobe();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule